// File: doc/BRIEF.md
# Carry Flag Generator for Integer Results

This block derives the two carry flags that an integer pipeline keeps next to a result: a full-width carry (CA) and a carry out of the low 32-bit half (CA32). It does not look at an adder carry-out. Instead it works the carries back from the finished result and from up to three source operands. This lets one flag unit serve every operation that sets carry, and the adder stays out of it.

A carry is inferred when any participating operand, read as unsigned, is larger than the result. The half-width carry uses the same test on the low halves. The exception is the plain add, where CA32 is the XOR of bit 32 of the result and bit 32 of each of the two addends. Before any test, the first operand can be complemented. An operand-valid vector chooses which operands take part. A two-bit mask marks flags that the operation has already written elsewhere, and each flag carries its own write enable. The outputs are registered by default, so the flags appear one clock after their inputs.

Top module: `carry_flag_gen`

## Requirements
- R1: While reset is high, all four outputs are 0 after the clock edge.
- R2: When inv_first_i is 1, operand 0 is bitwise complemented before it is used in any carry rule, including the add rule of R4.
- R3: ca_o is 1 exactly when some operand whose op_vld_i bit is set is unsigned-greater than res_i over all 64 bits. An operand equal to the result gives no carry.
- R4: When is_add_i is 1, ca32_o equals res_i[32] XOR (op_vld_i[0] AND operand0[32]) XOR (op_vld_i[1] AND op1_i[32]). Bit 32 has weight 2^32. Operand 2 has no part in this rule.
- R5: In an add with op_vld_i[1] = 0, op1_i[32] has no effect on ca32_o.
- R6: When is_add_i is 0, ca32_o is 1 exactly when the low 32 bits of some valid operand, read as unsigned, exceed res_i[31:0]. Upper bits play no part.
- R7: ca_we_o is carry_en_i AND NOT done_mask_i[0]. ca32_we_o is carry_en_i AND NOT done_mask_i[1].
- R8: When carry_en_i is 0, both write enables are 0.
- R9: An operand whose op_vld_i bit is 0 does not affect ca_o or ca32_o. With no valid operand and is_add_i at 0, both flags are 0.
- R10: With REG_OUT = 1, the outputs reflect the inputs sampled at the previous rising clock edge and do not change between edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op0_i | input | 64 | Operand 0 (the one that can be inverted) |
| op1_i | input | 64 | Operand 1 |
| op2_i | input | 64 | Operand 2 |
| res_i | input | 64 | Result of the operation |
| inv_first_i | input | 1 | Complement operand 0 before use |
| is_add_i | input | 1 | Operation is a plain add (selects the CA32 rule) |
| op_vld_i | input | 3 | Per-operand participation bits, bit n for operand n |
| carry_en_i | input | 1 | Operation writes carry flags |
| done_mask_i | input | 2 | Bit 0: CA already written; bit 1: CA32 already written |
| ca_o | output | 1 | Full-width carry flag |
| ca_we_o | output | 1 | Write enable for ca_o |
| ca32_o | output | 1 | Half-width carry flag |
| ca32_we_o | output | 1 | Write enable for ca32_o |

## Verification
Several operand and result pairs sit just around the full-width and half-width boundaries: equal, one above and one below. These show whether the comparison is strict and unsigned. One case has a low half of all ones and a result of exactly 2^32. There the two carries disagree, which separates the 64-bit compare from the 32-bit compare. Add cases switch bit 32 of each term on and off, and also mark operand 1 invalid, to separate the XOR rule from the compare rule. Random operands, many of them placed within a few units of the result, then cover mixed validity, inversion and mask settings against a reference model.

// File: rtl/carry_flag_pkg.sv
package carry_flag_pkg;

  localparam int unsigned NUM_OPS = 3;

  typedef struct packed {
    logic ca;
    logic ca_we;
    logic ca32;
    logic ca32_we;
  } cflags_t;

endpackage

// File: rtl/carry_slice_cmp.sv
// Unsigned greater-than built from slices; yields full-width and low-half results
module carry_slice_cmp #(
  parameter int unsigned W  = 64,
  parameter int unsigned HW = 32,
  parameter int unsigned SW = 16
) (
  input  logic [W-1:0] lhs,
  input  logic [W-1:0] rhs,
  output logic         gt_full,
  output logic         gt_half
);
  localparam int unsigned NS = W / SW;
  localparam int unsigned NH = HW / SW;

  logic s_gt  [NS];
  logic s_eq  [NS];
  logic chain [NS];

  for (genvar g = 0; g < NS; g++) begin : g_slice
    assign s_gt[g] = lhs[g*SW +: SW] > rhs[g*SW +: SW];
    assign s_eq[g] = lhs[g*SW +: SW] == rhs[g*SW +: SW];
    if (g == 0) begin : g_lsb
      assign chain[g] = s_gt[g];
    end else begin : g_up
      // prefix over bits [(g+1)*SW-1:0]
      assign chain[g] = s_gt[g] | (s_eq[g] & chain[g-1]);
    end
  end

  assign gt_full = chain[NS-1];
  assign gt_half = chain[NH-1];
endmodule

// File: rtl/carry_operand_stage.sv
// Applies optional inversion of operand 0
module carry_operand_stage #(
  parameter int unsigned W = 64,
  parameter int unsigned N = 3
) (
  input  logic [N-1:0][W-1:0] ops_in,
  input  logic                inv_first,
  output logic [N-1:0][W-1:0] ops_out
);
  for (genvar g = 0; g < N; g++) begin : g_op
    if (g == 0) begin : g_first
      assign ops_out[g] = inv_first ? ~ops_in[g] : ops_in[g];
    end else begin : g_rest
      assign ops_out[g] = ops_in[g];
    end
  end
endmodule

// File: rtl/carry_gt_reduce.sv
// One comparator per operand, qualified by the valid bits and OR-reduced
module carry_gt_reduce #(
  parameter int unsigned W  = 64,
  parameter int unsigned HW = 32,
  parameter int unsigned SW = 16,
  parameter int unsigned N  = 3
) (
  input  logic [N-1:0][W-1:0] ops,
  input  logic [N-1:0]        vld,
  input  logic [W-1:0]        res,
  output logic                any_full,
  output logic                any_half
);
  logic [N-1:0] gt_f;
  logic [N-1:0] gt_h;

  for (genvar g = 0; g < N; g++) begin : g_cmp
    carry_slice_cmp #(.W(W), .HW(HW), .SW(SW)) u_cmp (
      .lhs     (ops[g]),
      .rhs     (res),
      .gt_full (gt_f[g]),
      .gt_half (gt_h[g])
    );
  end

  assign any_full = |(gt_f & vld);
  assign any_half = |(gt_h & vld);
endmodule

// File: rtl/carry_add32_rule.sv
// Half-width carry of a two-input add, recovered from bit BIT of each term
module carry_add32_rule #(
  parameter int unsigned W   = 64,
  parameter int unsigned BIT = 32
) (
  input  logic [W-1:0] res,
  input  logic [W-1:0] a0,
  input  logic [W-1:0] a1,
  input  logic         v0,
  input  logic         v1,
  output logic         c32
);
  assign c32 = res[BIT] ^ (v0 & a0[BIT]) ^ (v1 & a1[BIT]);
endmodule

// File: rtl/carry_flag_gen.sv
module carry_flag_gen
  import carry_flag_pkg::*;
#(
  parameter int unsigned DATA_W  = 64,
  parameter int unsigned HALF_W  = 32,
  parameter int unsigned SLICE_W = 16,
  parameter bit          REG_OUT = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] op0_i,
  input  logic [DATA_W-1:0] op1_i,
  input  logic [DATA_W-1:0] op2_i,
  input  logic [DATA_W-1:0] res_i,
  input  logic              inv_first_i,
  input  logic              is_add_i,
  input  logic [2:0]        op_vld_i,
  input  logic              carry_en_i,
  input  logic [1:0]        done_mask_i,
  output logic              ca_o,
  output logic              ca_we_o,
  output logic              ca32_o,
  output logic              ca32_we_o
);
  localparam int unsigned N       = NUM_OPS;
  localparam int unsigned ADD_BIT = HALF_W;

  logic [N-1:0][DATA_W-1:0] ops_raw;
  logic [N-1:0][DATA_W-1:0] ops_prep;
  logic any_full;
  logic any_half;
  logic add_c32;
  cflags_t nxt;
  cflags_t cur;

  assign ops_raw[0] = op0_i;
  assign ops_raw[1] = op1_i;
  assign ops_raw[2] = op2_i;

  carry_operand_stage #(.W(DATA_W), .N(N)) u_prep (
    .ops_in    (ops_raw),
    .inv_first (inv_first_i),
    .ops_out   (ops_prep)
  );

  carry_gt_reduce #(.W(DATA_W), .HW(HALF_W), .SW(SLICE_W), .N(N)) u_gt (
    .ops      (ops_prep),
    .vld      (op_vld_i),
    .res      (res_i),
    .any_full (any_full),
    .any_half (any_half)
  );

  carry_add32_rule #(.W(DATA_W), .BIT(ADD_BIT)) u_add (
    .res (res_i),
    .a0  (ops_prep[0]),
    .a1  (ops_prep[1]),
    .v0  (op_vld_i[0]),
    .v1  (op_vld_i[1]),
    .c32 (add_c32)
  );

  always_comb begin
    nxt.ca      = any_full;
    nxt.ca32    = is_add_i ? add_c32 : any_half;
    nxt.ca_we   = carry_en_i & ~done_mask_i[0];
    nxt.ca32_we = carry_en_i & ~done_mask_i[1];
  end

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) cur <= '0;
      else     cur <= nxt;
    end
  end else begin : g_comb
    assign cur = nxt;
  end

  assign ca_o      = cur.ca;
  assign ca_we_o   = cur.ca_we;
  assign ca32_o    = cur.ca32;
  assign ca32_we_o = cur.ca32_we;
endmodule

// File: rtl/carry_flag_gen_chk.sv
module carry_flag_gen_chk #(
  parameter int unsigned DATA_W  = 64,
  parameter int unsigned HALF_W  = 32,
  parameter bit          REG_OUT = 1'b1
) (
  input logic              clk,
  input logic              rst,
  input logic [DATA_W-1:0] op0_i,
  input logic [DATA_W-1:0] op1_i,
  input logic [DATA_W-1:0] res_i,
  input logic              inv_first_i,
  input logic              is_add_i,
  input logic [2:0]        op_vld_i,
  input logic              carry_en_i,
  input logic [1:0]        done_mask_i,
  input logic              ca_o,
  input logic              ca_we_o,
  input logic              ca32_o,
  input logic              ca32_we_o
);
  if (REG_OUT) begin : g_props
    AST_WE_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
      (ca_we_o || ca32_we_o) |-> $past(carry_en_i)); // R8

    AST_CA_WE_MASK: assert property (@(posedge clk) disable iff (rst)
      ca_we_o |-> !$past(done_mask_i[0])); // R7

    AST_CA32_WE_MASK: assert property (@(posedge clk) disable iff (rst)
      ca32_we_o |-> !$past(done_mask_i[1])); // R7

    AST_CA_WE_ON: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(carry_en_i) && !$past(done_mask_i[0])) |-> ca_we_o); // R7

    AST_CA_RESULT_MAX: assert property (@(posedge clk) disable iff (rst)
      ($past(res_i) == {DATA_W{1'b1}}) |-> !ca_o); // R3

    AST_ADD_CA32: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(is_add_i)) |->
        (ca32_o == ($past(res_i[HALF_W])
                    ^ ($past(op_vld_i[0]) & ($past(op0_i[HALF_W]) ^ $past(inv_first_i)))
                    ^ ($past(op_vld_i[1]) & $past(op1_i[HALF_W]))))); // R4

    AST_NO_VALID: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && ($past(op_vld_i) == 3'b000) && !$past(is_add_i)) |->
        (!ca_o && !ca32_o)); // R9
  end
endmodule

bind carry_flag_gen carry_flag_gen_chk #(
  .DATA_W (DATA_W),
  .HALF_W (HALF_W),
  .REG_OUT(REG_OUT)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .op0_i       (op0_i),
  .op1_i       (op1_i),
  .res_i       (res_i),
  .inv_first_i (inv_first_i),
  .is_add_i    (is_add_i),
  .op_vld_i    (op_vld_i),
  .carry_en_i  (carry_en_i),
  .done_mask_i (done_mask_i),
  .ca_o        (ca_o),
  .ca_we_o     (ca_we_o),
  .ca32_o      (ca32_o),
  .ca32_we_o   (ca32_we_o)
);

// File: tb/carry_flag_gen_test.sv
`timescale 1ns/1ps
module carry_flag_gen_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] op0 = '0, op1 = '0, op2 = '0, res = '0;
  logic        inv = 1'b0, add = 1'b0, cen = 1'b0;
  logic [2:0]  vld = '0;
  logic [1:0]  dm  = '0;
  logic        ca, ca_we, ca32, ca32_we;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  carry_flag_gen uut (
    .clk(clk), .rst(rst), .op0_i(op0), .op1_i(op1), .op2_i(op2), .res_i(res),
    .inv_first_i(inv), .is_add_i(add), .op_vld_i(vld), .carry_en_i(cen),
    .done_mask_i(dm), .ca_o(ca), .ca_we_o(ca_we), .ca32_o(ca32), .ca32_we_o(ca32_we)
  );

  // expected {ca, ca_we, ca32, ca32_we}
  function automatic logic [3:0] model();
    logic [63:0] a0;
    logic e_ca, e_c32;
    a0    = inv ? ~op0 : op0;
    e_ca  = (vld[0] && a0 > res) || (vld[1] && op1 > res) || (vld[2] && op2 > res);
    if (add)
      e_c32 = res[32] ^ (vld[0] & a0[32]) ^ (vld[1] & op1[32]);
    else
      e_c32 = (vld[0] && a0[31:0] > res[31:0]) || (vld[1] && op1[31:0] > res[31:0])
           || (vld[2] && op2[31:0] > res[31:0]);
    return {e_ca, cen & ~dm[0], e_c32, cen & ~dm[1]};
  endfunction

  task automatic check(input string tag, input logic [3:0] exp);
    n_run++;
    if ({ca, ca_we, ca32, ca32_we} !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", tag, {ca, ca_we, ca32, ca32_we}, exp);
    end
  endtask

  // drive at negedge, registered result visible at the following negedge
  task automatic apply(input string tag, input logic [63:0] a, b, c, r,
                       input logic i, ad, input logic [2:0] v,
                       input logic e, input logic [1:0] m);
    logic [3:0] exp;
    @(negedge clk);
    op0 = a; op1 = b; op2 = c; res = r; inv = i; add = ad; vld = v; cen = e; dm = m;
    exp = model();
    @(negedge clk);
    check(tag, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [3:0] prev;
    void'($urandom(32'h5EED_1234));
    // R1: reset clears outputs even with active inputs
    op0 = 64'd9; res = 64'd1; vld = 3'b001; cen = 1'b1;
    repeat (3) @(negedge clk);
    check("R1", 4'b0000);
    rst = 1'b0;

    // R3: strict unsigned compare
    apply("R3", 64'd5, 0, 0, 64'd3, 0, 0, 3'b001, 1, 2'b00);
    apply("R3", 64'd3, 0, 0, 64'd5, 0, 0, 3'b001, 1, 2'b00);
    apply("R3", 64'd7, 0, 0, 64'd7, 0, 0, 3'b001, 1, 2'b00);
    apply("R3", 0, 0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h8000_0000_0000_0000, 0, 0, 3'b100, 1, 2'b00);
    // R2: inversion of operand 0
    apply("R2", 64'd0, 0, 0, 64'd10, 1, 0, 3'b001, 1, 2'b00);
    apply("R2", 64'hFFFF_FFFF_FFFF_FFFF, 0, 0, 64'd0, 1, 0, 3'b001, 1, 2'b00);
    apply("R2", 64'h0000_0001_0000_0000, 0, 0, 64'd0, 1, 1, 3'b001, 1, 2'b00);
    // R9: invalid operands ignored
    apply("R9", 64'd1, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF, 64'd2, 0, 0, 3'b001, 1, 2'b00);
    apply("R9", 64'hFF, 64'hFF, 64'hFF, 64'd0, 0, 0, 3'b000, 1, 2'b00);
    // R6: low-half compare differs from full compare
    apply("R6", 64'h0000_0000_FFFF_FFFF, 0, 0, 64'h0000_0001_0000_0000, 0, 0, 3'b001, 1, 2'b00);
    apply("R6", 64'h0000_0002_0000_0001, 0, 0, 64'h0000_0001_0000_0005, 0, 0, 3'b001, 1, 2'b00);
    // R4: add rule over bit 32
    apply("R4", 64'd0, 64'd0, 0, 64'h0000_0001_0000_0000, 0, 1, 3'b011, 1, 2'b00);
    apply("R4", 64'h0000_0001_0000_0000, 64'h0000_0001_0000_0000, 0, 64'h0000_0001_0000_0000, 0, 1, 3'b011, 1, 2'b00);
    apply("R4", 64'h0000_0001_0000_0000, 0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd0, 0, 1, 3'b111, 1, 2'b00);
    // R5: add with operand 1 absent
    apply("R5", 64'd0, 64'h0000_0001_0000_0000, 0, 64'd0, 0, 1, 3'b001, 1, 2'b00);
    // R7: already-done mask
    apply("R7", 64'd5, 0, 0, 64'd3, 0, 0, 3'b001, 1, 2'b01);
    apply("R7", 64'd5, 0, 0, 64'd3, 0, 0, 3'b001, 1, 2'b10);
    apply("R7", 64'd5, 0, 0, 64'd3, 0, 0, 3'b001, 1, 2'b11);
    // R8: carry enable low
    apply("R8", 64'd5, 0, 0, 64'd3, 0, 0, 3'b001, 0, 2'b00);

    // R10: outputs hold until the next edge
    apply("R10", 64'd5, 0, 0, 64'd3, 0, 0, 3'b001, 1, 2'b00);
    prev = {ca, ca_we, ca32, ca32_we};
    @(negedge clk);
    op0 = 64'd1; res = 64'd9; cen = 1'b0;
    #3;
    check("R10", prev);
    @(negedge clk);
    check("R10", model());

    // random mix, many results close to an operand
    for (int k = 0; k < 400; k++) begin
      logic [63:0] a, b, c, r;
      logic [2:0]  v;
      logic        ad;
      a  = {$urandom(), $urandom()};
      b  = {$urandom(), $urandom()};
      c  = {$urandom(), $urandom()};
      r  = {$urandom(), $urandom()};
      if ($urandom_range(3) == 0) r = a + 64'($urandom_range(4)) - 64'd2;
      if ($urandom_range(3) == 0) r[31:0] = b[31:0];
      v  = 3'($urandom_range(7));
      ad = 1'($urandom_range(1));
      apply(ad ? "R4" : "R6", a, b, c, r, 1'($urandom_range(1)), ad, v,
            1'($urandom_range(3) != 0), 2'($urandom_range(3)));
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule